// File: doc/BRIEF.md
# Sum of Absolute Differences Engine

This block measures how alike two blocks of pixel data are. Both blocks sit in external byte memories of equal depth, 256 entries by default, which hold a 16x16 tile. A one-cycle `go` pulse starts a run. The engine drives one address to both memories at once. It reads one byte from each memory per element and adds the unsigned magnitude of their difference to a running total. When every element has been visited, the total is copied into the `sad` output register and `done` pulses.

A small controller sequences the run through five states: idle, initialise, bound check, accumulate, and latch. Each element therefore costs two cycles, one to test the index and one to accumulate. The datapath holds an index one bit wider than the address, so the test for the end of the run is a simple compare. It also holds the running sum and the result register. The memories answer combinationally, so data for the presented address is valid in the same cycle. Any threshold decision on the result belongs to the caller.

Top module: `sad_engine`

## Requirements
- R1: After reset, `sad` is 0, `done` is 0 and `memRd` is 0.
- R2: A completed run leaves in `sad` the sum over every address 0..NUM_ELEMS-1 of |aData - bData|, where both bytes are treated as unsigned.
- R3: During a run, `memRd` is high exactly NUM_ELEMS times. On its k-th assertion (k counting from 0), `memAddr` equals k.
- R4: `memRd` is never high on two consecutive cycles.
- R5: `done` is high for exactly one cycle. It rises on the (2*NUM_ELEMS+4)th rising edge, counting the edge that samples `go` as the first, which is the 516th edge by default. From that cycle `sad` shows the new result.
- R6: A `go` pulse that arrives while a run is in progress has no effect. The run finishes on the same edge and gives the same result as a run without that pulse.
- R7: Between runs, `sad` holds its value, and `memRd` and `done` stay low, whatever the memory contents do.
- R8: The sum does not wrap when every element differs by the largest amount. For 256 elements of 255 against 0, the result is 65280.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, sampled only while idle |
| memAddr | output | ADDR_W (8) | Address shared by both memories |
| memRd | output | 1 | Read strobe, high in accumulate cycles |
| aData | input | ELEM_W (8) | Byte from memory A at memAddr |
| bData | input | ELEM_W (8) | Byte from memory B at memAddr |
| sad | output | SUM_W (32) | Latched sum of absolute differences |
| done | output | 1 | One-cycle pulse when `sad` is updated |

## Verification
The bench builds the block with its default parameters: 256 elements of 8 bits and a 32-bit sum. A full run is only a few hundred cycles, so every address of the real tile size is visited in every run. The test patterns cover all-zero data, the largest per-element difference in both directions, mirrored ramps, and pseudo-random data. For each pattern the bench computes the expected total arithmetically and checks the read order and the exact completion edge. Stray `go` pulses in the middle of a run, and memory changes between runs, show that the result and its timing are unaffected.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef struct packed {
    logic idxClr;
    logic idxInc;
    logic sumClr;
    logic sumLd;
    logic sadLd;
  } sadStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_CHECK = 3'd2,
    ST_ACCUM = 3'd3,
    ST_LATCH = 3'd4
  } sadState_t;
endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     go,
  input  logic     idxLtN,
  output sadStrb_t strb,
  output logic     memRd
);
  sadState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    memRd     = 1'b0;
    unique case (state)
      ST_IDLE:  if (go) nextState = ST_INIT;
      ST_INIT: begin
        strb.idxClr = 1'b1;
        strb.sumClr = 1'b1;
        nextState   = ST_CHECK;
      end
      ST_CHECK: nextState = idxLtN ? ST_ACCUM : ST_LATCH;
      ST_ACCUM: begin
        strb.sumLd  = 1'b1;
        strb.idxInc = 1'b1;
        memRd       = 1'b1;
        nextState   = ST_CHECK;
      end
      ST_LATCH: begin
        strb.sadLd = 1'b1;
        nextState  = ST_IDLE;
      end
      default:  nextState = ST_IDLE;
    endcase
  end

  // R4: the accumulate state is always followed by a bound check
  assert_rd_spaced_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !memRd);

  // R6: go seen outside idle never restarts the run
  assert_go_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (state != ST_INIT));

  // R2: the result is only latched once the index has run out
  assert_latch_after_end_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && !idxLtN) |=> strb.sadLd);
endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
#(
  parameter int ELEM_W    = 8,
  parameter int NUM_ELEMS = 256,
  parameter int SUM_W     = 32,
  localparam int ADDR_W   = $clog2(NUM_ELEMS),
  localparam int IDX_W    = ADDR_W + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  sadStrb_t          strb,
  input  logic [ELEM_W-1:0] aData,
  input  logic [ELEM_W-1:0] bData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              idxLtN,
  output logic [SUM_W-1:0]  sad,
  output logic              done
);
  logic [IDX_W-1:0]  idx;
  logic [SUM_W-1:0]  sum;
  logic [ELEM_W-1:0] absDiff;

  assign absDiff = (aData >= bData) ? (aData - bData) : (bData - aData);
  assign idxLtN  = idx < IDX_W'(NUM_ELEMS);
  assign memAddr = idx[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            idx <= '0;
    else if (strb.idxClr) idx <= '0;
    else if (strb.idxInc) idx <= idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           sum <= '0;
    else if (strb.sumClr) sum <= '0;
    else if (strb.sumLd)  sum <= sum + SUM_W'(absDiff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sad  <= '0;
      done <= 1'b0;
    end else begin
      done <= strb.sadLd;
      if (strb.sadLd) sad <= sum;
    end
  end

  // R3: index never passes the element count
  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    idx <= IDX_W'(NUM_ELEMS));

  // R8: accumulation never wraps downward
  assert_sum_no_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sumClr |=> sum >= $past(sum));

  // R7: the output register moves only on a latch
  assert_sad_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sadLd |=> $stable(sad));

  // R5: completion flag lasts a single cycle
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/sad_engine.sv
module sad_engine
  import sad_pkg::*;
#(
  parameter int ELEM_W    = 8,
  parameter int NUM_ELEMS = 256,
  parameter int SUM_W     = 32,
  localparam int ADDR_W   = $clog2(NUM_ELEMS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [ELEM_W-1:0] aData,
  input  logic [ELEM_W-1:0] bData,
  output logic [SUM_W-1:0]  sad,
  output logic              done
);
  sadStrb_t strb;
  logic     idxLtN;

  sad_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .go     (go),
    .idxLtN (idxLtN),
    .strb   (strb),
    .memRd  (memRd)
  );

  sad_datapath #(
    .ELEM_W    (ELEM_W),
    .NUM_ELEMS (NUM_ELEMS),
    .SUM_W     (SUM_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .aData   (aData),
    .bData   (bData),
    .memAddr (memAddr),
    .idxLtN  (idxLtN),
    .sad     (sad),
    .done    (done)
  );
endmodule

// File: tb/sad_engine_tb.sv
module sad_engine_tb;
  localparam int N = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        go = 1'b0;
  logic [7:0]  memAddr;
  logic        memRd;
  logic [7:0]  aData, bData;
  logic [31:0] sad;
  logic        done;

  logic [7:0] memA [N];
  logic [7:0] memB [N];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign aData = memA[memAddr];
  assign bData = memB[memAddr];

  sad_engine u_dut (
    .clk(clk), .rstN(rstN), .go(go), .memAddr(memAddr), .memRd(memRd),
    .aData(aData), .bData(bData), .sad(sad), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expectedSum();
    longint s = 0;
    for (int i = 0; i < N; i++)
      s += (memA[i] >= memB[i]) ? (memA[i] - memB[i]) : (memB[i] - memA[i]);
    return s;
  endfunction

  // run one computation; injectAt > 0 raises go again at that edge count
  task automatic doRun(input string tag, input int injectAt);
    int  n;
    int  rdCount = 0;
    bit  prevRd = 0;
    bit  orderOk = 1;
    bit  spacingOk = 1;
    int  badAddr = 0;
    longint exp;
    exp = expectedSum();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    n = 1;
    while (!done && n < 2000) begin
      if (memRd) begin
        if (memAddr != rdCount[7:0] && orderOk) begin orderOk = 0; badAddr = memAddr; end
        if (prevRd) spacingOk = 0;
        rdCount++;
      end
      prevRd = memRd;
      go = (injectAt > 0 && n == injectAt);
      @(negedge clk);
      go = 1'b0;
      n++;
    end
    check(n == 2*N + 4, {"R5 done edge ", tag}, n, 2*N + 4);
    check(sad == exp[31:0], {"R2 sum ", tag}, sad, exp);
    check(rdCount == N, {"R3 read count ", tag}, rdCount, N);
    check(orderOk, {"R3 address order ", tag}, badAddr, 0);
    check(spacingOk, {"R4 read spacing ", tag}, spacingOk, 1);
    if (injectAt > 0) check(sad == exp[31:0], {"R6 mid-run go ", tag}, sad, exp);
    @(negedge clk);
    check(done == 1'b0, {"R5 done width ", tag}, done, 0);
  endtask

  initial begin
    int seed;
    for (int i = 0; i < N; i++) begin memA[i] = '0; memB[i] = '0; end
    repeat (3) @(negedge clk);
    check(sad == 0, "R1 sad reset", sad, 0);
    check(done == 0, "R1 done reset", done, 0);
    check(memRd == 0, "R1 rd reset", memRd, 0);
    rstN = 1'b1;
    @(negedge clk);

    doRun("zeros", 0);

    for (int i = 0; i < N; i++) begin memA[i] = 8'd255; memB[i] = 8'd0; end
    doRun("max a>b", 0);
    check(sad == 32'd65280, "R8 max sum", sad, 65280);

    for (int i = 0; i < N; i++) begin memA[i] = 8'd0; memB[i] = 8'd255; end
    doRun("max b>a", 0);
    check(sad == 32'd65280, "R8 max sum reversed", sad, 65280);

    for (int i = 0; i < N; i++) begin memA[i] = 8'(i); memB[i] = 8'(255 - i); end
    doRun("ramps", 0);

    seed = 12345;
    for (int i = 0; i < N; i++) begin
      seed = seed * 1103515245 + 12345;
      memA[i] = seed[23:16];
      seed = seed * 1103515245 + 12345;
      memB[i] = seed[23:16];
    end
    doRun("random", 0);
    doRun("random go inject early", 7);
    doRun("random go inject late", 513);

    // R7: hold between runs while memory contents change
    begin
      logic [31:0] held;
      bit quiet = 1;
      held = sad;
      for (int i = 0; i < N; i++) begin memA[i] = 8'(i * 3); memB[i] = 8'(i * 7); end
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (memRd || done) quiet = 0;
      end
      check(sad == held, "R7 sad held", sad, held);
      check(quiet, "R7 idle outputs quiet", quiet, 1);
    end
    doRun("after hold", 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule